// File: doc/BRIEF.md
# Character RAM Address Counter

This block keeps the single 7-bit address pointer that a character-display controller uses for both its display RAM and its character-generator RAM. A decoded "set display address" or "set generator address" command loads the pointer and selects which RAM it points into. After that, every completed data access moves the pointer by one, either up or down, according to the entry direction bit.

In display mode the pointer follows the visible line layout. With one line it runs through 00h..4Fh. With two lines it runs through 00h..27h and 40h..67h and steps over the unused gap between them. In generator mode it is a plain 6-bit pointer. The pointer is always presented as the RAM address. When a status read is decoded, the pointer is also driven onto the data bus.

The RAM arrays, the command decoder and the bus timing are outside this block. It takes only single-cycle strobes and level mode bits.

Top module: `addr_ctr`

## Requirements
- R1: After reset the pointer is 00h and display RAM is selected (`genSel` = 0).
- R2: A display-load strobe loads the pointer from `cmdAddr` and selects display RAM. A generator-load strobe loads `cmdAddr[5:0]` with bit 6 cleared and selects generator RAM. If both strobes are high together, the display load wins.
- R3: An access strobe moves the pointer by one: up when `entryInc` = 1, down when `entryInc` = 0. The new value is visible in the cycle after the strobe. A load in the same cycle takes priority over the step. With no strobe the pointer holds its value.
- R4: With display RAM selected and `twoLine` = 0, stepping up from 4Fh gives 00h, and stepping down from 00h gives 4Fh.
- R5: With display RAM selected and `twoLine` = 1, the pointer wraps as follows: up from 27h gives 40h, up from 67h gives 00h, down from 40h gives 27h, and down from 00h gives 67h.
- R6: With generator RAM selected, the pointer steps modulo 64 and bit 6 stays 0.
- R7: A display load outside the valid range is clamped. With one line, 50h..7Fh loads 00h. With two lines, 28h..3Fh loads 40h and 68h..7Fh loads 00h.
- R8: `busOe` is 1 exactly when `regSel` = 0 and `readNotWrite` = 1. In that case `busOut` equals the pointer; otherwise `busOut` is 0.
- R9: `ramAddr` always equals the pointer, and `genSel` = 1 exactly while generator RAM is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| setDispStb | input | 1 | Load strobe for a display-RAM address |
| setGenStb | input | 1 | Load strobe for a generator-RAM address |
| cmdAddr | input | 7 | Address carried by the load command |
| accessStb | input | 1 | A data read or write has completed |
| entryInc | input | 1 | Step direction: 1 = up, 0 = down |
| twoLine | input | 1 | Display layout: 1 = two lines, 0 = one line |
| regSel | input | 1 | Register select from the bus decoder |
| readNotWrite | input | 1 | Bus direction: 1 = read |
| ramAddr | output | 7 | Current pointer, used as the RAM address |
| genSel | output | 1 | 1 = generator RAM selected |
| busOut | output | 7 | Pointer value for a status read |
| busOe | output | 1 | Status read is active |

## Verification
The hardest behaviour to reach from the ports is the two-line wrap chain. It is only hit when long runs of steps in each direction cross 27h, 40h, 67h and 00h in turn. The bench loads a known start address and runs more than a full 80-position cycle up, then down. After each step it compares the pointer with a linear-index model that maps the two line ranges onto positions 0..79. Every load value 00h..7Fh is also swept in both line modes to reach every clamp band.

// File: rtl/addr_ctr_pkg.sv
package addr_ctr_pkg;

  typedef enum logic {
    RAM_DISP = 1'b0,
    RAM_GEN  = 1'b1
  } ramSel_e;

  typedef struct packed {
    logic loadDisp;
    logic loadGen;
    logic step;
    logic stepUp;
  } ctlStb_t;

endpackage

// File: rtl/addr_ctr_ctrl.sv
module addr_ctr_ctrl
  import addr_ctr_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    setDispStb,
  input  logic    setGenStb,
  input  logic    accessStb,
  input  logic    entryInc,
  output ctlStb_t ctl,
  output ramSel_e ramSel
);

  // Strobe priority: display load, then generator load, then step.
  always_comb begin
    ctl.loadDisp = setDispStb;
    ctl.loadGen  = setGenStb & ~setDispStb;
    ctl.step     = accessStb & ~setDispStb & ~setGenStb;
    ctl.stepUp   = entryInc;
  end

  always_ff @(posedge clk) begin
    if (!rstN)             ramSel <= RAM_DISP;
    else if (ctl.loadDisp) ramSel <= RAM_DISP;
    else if (ctl.loadGen)  ramSel <= RAM_GEN;
  end

  // R2: a display load overrides a simultaneous generator load.
  a_r2_disp_wins: assert property (@(posedge clk) disable iff (!rstN)
    setDispStb |=> ramSel == RAM_DISP);

  // R2: a lone generator load selects generator RAM.
  a_r2_gen_sel: assert property (@(posedge clk) disable iff (!rstN)
    (setGenStb && !setDispStb) |=> ramSel == RAM_GEN);

  // R9: RAM selection changes only on a load command.
  a_r9_sel_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!setDispStb && !setGenStb) |=> $stable(ramSel));

endmodule

// File: rtl/addr_ctr_dp.sv
module addr_ctr_dp
  import addr_ctr_pkg::*;
#(
  parameter int ADDR_W     = 7,
  parameter int GEN_W      = 6,
  parameter int LINE_LEN   = 40,
  parameter int LINE2_BASE = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStb_t           ctl,
  input  ramSel_e           ramSel,
  input  logic              twoLine,
  input  logic [ADDR_W-1:0] cmdAddr,
  output logic [ADDR_W-1:0] ptr
);

  localparam int HI_W = ADDR_W - GEN_W;
  localparam logic [ADDR_W-1:0] ZERO     = '0;
  localparam logic [ADDR_W-1:0] ONE      = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] ONE_LAST = ADDR_W'(2 * LINE_LEN - 1);
  localparam logic [ADDR_W-1:0] L1_LAST  = ADDR_W'(LINE_LEN - 1);
  localparam logic [ADDR_W-1:0] L2_BASE  = ADDR_W'(LINE2_BASE);
  localparam logic [ADDR_W-1:0] L2_LAST  = ADDR_W'(LINE2_BASE + LINE_LEN - 1);

  logic [ADDR_W-1:0] clampVal;
  logic [ADDR_W-1:0] dispUp;
  logic [ADDR_W-1:0] dispDn;
  logic [GEN_W-1:0]  genStep;
  logic [ADDR_W-1:0] stepVal;
  logic [ADDR_W-1:0] ptrNext;

  // Clamp an out-of-range display load to the start of the nearest valid line.
  always_comb begin
    if (!twoLine) begin
      clampVal = (cmdAddr > ONE_LAST) ? ZERO : cmdAddr;
    end else if (cmdAddr <= L1_LAST) begin
      clampVal = cmdAddr;
    end else if (cmdAddr < L2_BASE) begin
      clampVal = L2_BASE;
    end else if (cmdAddr <= L2_LAST) begin
      clampVal = cmdAddr;
    end else begin
      clampVal = ZERO;
    end
  end

  // Display-mode step up, with the line-layout wraps.
  always_comb begin
    if (!twoLine)
      dispUp = (ptr == ONE_LAST) ? ZERO : ptr + ONE;
    else if (ptr == L1_LAST)
      dispUp = L2_BASE;
    else if (ptr == L2_LAST)
      dispUp = ZERO;
    else
      dispUp = ptr + ONE;
  end

  // Display-mode step down, mirroring the up wraps.
  always_comb begin
    if (!twoLine)
      dispDn = (ptr == ZERO) ? ONE_LAST : ptr - ONE;
    else if (ptr == L2_BASE)
      dispDn = L1_LAST;
    else if (ptr == ZERO)
      dispDn = L2_LAST;
    else
      dispDn = ptr - ONE;
  end

  // Generator mode: plain 6-bit pointer, modulo 64.
  always_comb begin
    if (ctl.stepUp) genStep = ptr[GEN_W-1:0] + GEN_W'(1);
    else            genStep = ptr[GEN_W-1:0] - GEN_W'(1);
  end

  always_comb begin
    if (ramSel == RAM_GEN) stepVal = {{HI_W{1'b0}}, genStep};
    else if (ctl.stepUp)   stepVal = dispUp;
    else                   stepVal = dispDn;
  end

  always_comb begin
    if (ctl.loadDisp)     ptrNext = clampVal;
    else if (ctl.loadGen) ptrNext = {{HI_W{1'b0}}, cmdAddr[GEN_W-1:0]};
    else if (ctl.step)    ptrNext = stepVal;
    else                  ptrNext = ptr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) ptr <= '0;
    else       ptr <= ptrNext;
  end

  // R3: with no load and no step the pointer holds.
  a_r3_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.loadDisp && !ctl.loadGen && !ctl.step) |=> $stable(ptr));

  // R4: one-line wrap up from the last position.
  a_r4_one_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.step && ctl.stepUp && ramSel == RAM_DISP && !twoLine && ptr == ONE_LAST)
    |=> ptr == ZERO);

  // R5: two-line jump from the end of line 1 over the gap.
  a_r5_gap_up: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.step && ctl.stepUp && ramSel == RAM_DISP && twoLine && ptr == L1_LAST)
    |=> ptr == L2_BASE);

  // R5: two-line jump from the start of line 2 back over the gap.
  a_r5_gap_dn: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.step && !ctl.stepUp && ramSel == RAM_DISP && twoLine && ptr == L2_BASE)
    |=> ptr == L1_LAST);

  // R7: a two-line display load never lands in the gap or past line 2.
  a_r7_clamp_two: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.loadDisp && twoLine)
    |=> (ptr <= L1_LAST || (ptr >= L2_BASE && ptr <= L2_LAST)));

endmodule

// File: rtl/addr_ctr.sv
module addr_ctr
  import addr_ctr_pkg::*;
#(
  parameter int ADDR_W     = 7,
  parameter int GEN_W      = 6,
  parameter int LINE_LEN   = 40,
  parameter int LINE2_BASE = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              setDispStb,
  input  logic              setGenStb,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic              accessStb,
  input  logic              entryInc,
  input  logic              twoLine,
  input  logic              regSel,
  input  logic              readNotWrite,
  output logic [ADDR_W-1:0] ramAddr,
  output logic              genSel,
  output logic [ADDR_W-1:0] busOut,
  output logic              busOe
);

  ctlStb_t           ctl;
  ramSel_e           ramSel;
  logic [ADDR_W-1:0] ptr;

  addr_ctr_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .setDispStb (setDispStb),
    .setGenStb  (setGenStb),
    .accessStb  (accessStb),
    .entryInc   (entryInc),
    .ctl        (ctl),
    .ramSel     (ramSel)
  );

  addr_ctr_dp #(
    .ADDR_W     (ADDR_W),
    .GEN_W      (GEN_W),
    .LINE_LEN   (LINE_LEN),
    .LINE2_BASE (LINE2_BASE)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .ramSel  (ramSel),
    .twoLine (twoLine),
    .cmdAddr (cmdAddr),
    .ptr     (ptr)
  );

  assign ramAddr = ptr;
  assign genSel  = (ramSel == RAM_GEN);
  assign busOe   = ~regSel & readNotWrite;
  assign busOut  = busOe ? ptr : '0;

  // R6: the upper pointer bits stay clear while generator RAM is selected.
  a_r6_gen_msb: assert property (@(posedge clk) disable iff (!rstN)
    genSel |-> ptr[ADDR_W-1:GEN_W] == '0);

  // R8: an active status read presents the RAM address.
  a_r8_status: assert property (@(posedge clk) disable iff (!rstN)
    busOe |-> busOut == ramAddr);

  // R1: the first cycle after reset shows address zero.
  a_r1_reset: assert property (@(posedge clk)
    !rstN |=> ramAddr == '0);

endmodule

// File: tb/addr_ctr_tb.sv
`timescale 1ns/1ps
module addr_ctr_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       setDispStb = 1'b0;
  logic       setGenStb = 1'b0;
  logic [6:0] cmdAddr = '0;
  logic       accessStb = 1'b0;
  logic       entryInc = 1'b1;
  logic       twoLine = 1'b0;
  logic       regSel = 1'b0;
  logic       readNotWrite = 1'b1;
  logic [6:0] ramAddr;
  logic       genSel;
  logic [6:0] busOut;
  logic       busOe;

  int checks = 0;
  int fails  = 0;
  int exp    = 0;

  always #2 clk = ~clk;

  addr_ctr u_dut (
    .clk(clk), .rstN(rstN), .setDispStb(setDispStb), .setGenStb(setGenStb),
    .cmdAddr(cmdAddr), .accessStb(accessStb), .entryInc(entryInc),
    .twoLine(twoLine), .regSel(regSel), .readNotWrite(readNotWrite),
    .ramAddr(ramAddr), .genSel(genSel), .busOut(busOut), .busOe(busOe)
  );

  task automatic check(input string req, input int act, input int expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  // Expected next pointer: display positions as a linear index 0..79.
  function automatic int model(input int a, input bit up, input bit two, input bit gen);
    int idx;
    if (gen) return (a + (up ? 1 : 63)) % 64;
    idx = (two && a >= 64) ? a - 24 : a;
    idx = (idx + (up ? 1 : 79)) % 80;
    return (two && idx >= 40) ? idx + 24 : idx;
  endfunction

  function automatic int clampModel(input int a, input bit two);
    if (!two) return (a >= 80) ? 0 : a;
    if (a < 40) return a;
    if (a < 64) return 64;
    if (a < 104) return a;
    return 0;
  endfunction

  task automatic loadDisp(input int a);
    @(negedge clk); setDispStb = 1'b1; cmdAddr = 7'(a);
    @(negedge clk); setDispStb = 1'b0;
  endtask

  task automatic loadGen(input int a);
    @(negedge clk); setGenStb = 1'b1; cmdAddr = 7'(a);
    @(negedge clk); setGenStb = 1'b0;
  endtask

  task automatic stepOnce(input bit up);
    @(negedge clk); accessStb = 1'b1; entryInc = up;
    @(negedge clk); accessStb = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 reset addr", ramAddr, 0);
    check("R1 reset sel", genSel, 0);

    // R8: every status-decode combination.
    for (int c = 0; c < 4; c++) begin
      regSel = c[1]; readNotWrite = c[0];
      #1;
      check("R8 busOe", busOe, (c == 1) ? 1 : 0);
      check("R8 busOut", busOut, (c == 1) ? ramAddr : 0);
    end
    regSel = 1'b0; readNotWrite = 1'b1;

    // R7 / R2: every load value in both line modes.
    for (int t = 0; t < 2; t++) begin
      twoLine = t[0];
      for (int a = 0; a < 128; a++) begin
        loadDisp(a);
        check("R7 clamp", ramAddr, clampModel(a, t[0]));
        check("R8 status value", busOut, clampModel(a, t[0]));
      end
      check("R2 disp sel", genSel, 0);
    end

    // R3 / R4 / R5: full cycles up then down in both layouts.
    for (int t = 0; t < 2; t++) begin
      twoLine = t[0];
      for (int d = 0; d < 2; d++) begin
        loadDisp(0);
        exp = 0;
        for (int s = 0; s < 85; s++) begin
          stepOnce(d == 0);
          exp = model(exp, d == 0, t[0], 1'b0);
          check(t ? "R5 two-line step" : "R4 one-line step", ramAddr, exp);
        end
      end
    end

    // R5: the four named wrap points.
    twoLine = 1'b1;
    loadDisp(39); stepOnce(1'b1); check("R5 27h up", ramAddr, 64);
    stepOnce(1'b0);               check("R5 40h down", ramAddr, 39);
    loadDisp(103); stepOnce(1'b1); check("R5 67h up", ramAddr, 0);
    stepOnce(1'b0);               check("R5 00h down", ramAddr, 103);

    // R6 / R2: generator loads and steps.
    for (int a = 0; a < 128; a += 5) begin
      loadGen(a);
      check("R2 gen load", ramAddr, a % 64);
      check("R9 gen sel", genSel, 1);
    end
    for (int d = 0; d < 2; d++) begin
      loadGen(0);
      exp = 0;
      for (int s = 0; s < 70; s++) begin
        stepOnce(d == 0);
        exp = model(exp, d == 0, 1'b0, 1'b1);
        check("R6 gen step", ramAddr, exp);
      end
    end

    // R2: both loads together, display wins.
    @(negedge clk); setDispStb = 1'b1; setGenStb = 1'b1; cmdAddr = 7'h12;
    @(negedge clk); setDispStb = 1'b0; setGenStb = 1'b0;
    check("R2 both addr", ramAddr, 18);
    check("R2 both sel", genSel, 0);

    // R3: a load beats a step in the same cycle, and idle cycles hold.
    @(negedge clk); setDispStb = 1'b1; accessStb = 1'b1; cmdAddr = 7'h05;
    @(negedge clk); setDispStb = 1'b0; accessStb = 1'b0;
    check("R3 load priority", ramAddr, 5);
    repeat (4) @(negedge clk);
    check("R3 hold", ramAddr, 5);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule